// File: doc/BRIEF.md
# Flash Command Sequencer with Program Bypass

This block sits behind the write port of a NOR-style flash model. Each bus write it sees (address, data byte and write strobe) moves a command-register state machine forward. A finished sequence hands a job to the embedded-algorithm controller. The job is one of a one-byte program, a sector erase or a whole-chip erase, passed as a one-cycle start pulse with a job code, address and data. The block tracks that job as busy until the controller reports completion.

A running erase can be frozen with a suspend byte and restarted with a resume byte. A bypass mode lets later programs skip the two unlock writes. A single write enters a parameter-query mode. The block also tells the read path what a read should return: array contents, query-table contents or operation status.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset `op_busy`, `erase_held`, `bypass_on` and `op_start` are 0, and `rd_sel` is 0 (array).
- R2: The writes AAh@555h, 55h@2AAh and A0h@555h, followed by any write PA/PD, raise `op_start` for exactly one cycle on the cycle after the PA/PD write. In that cycle `op_kind`=1 (program), `op_addr`=PA, `op_data`=PD and `op_busy`=1. `op_busy` drops on the cycle after `algo_done`.
- R3: A write that does not match the step the sequence expects returns the sequencer to read mode. The wrong byte, the wrong unlock address or an unknown third byte all count as a mismatch. A following address/data write then starts nothing.
- R4: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h@SA starts a sector erase (`op_kind`=2, `op_addr`=SA). Ending instead with 10h@555h starts a chip erase (`op_kind`=3).
- R5: While a job runs and is not held, `rd_sel`=2 (status). Every write other than a suspend is ignored.
- R6: While an erase runs, a B0h write at any address sets `erase_held` on the next cycle and `rd_sel` returns to 0. Any other byte leaves the erase running. `algo_done` is ignored while held. B0h during a program has no effect.
- R7: While held, 30h at any address clears `erase_held` without a new start or a change of `op_kind`. A further 30h is ignored. A later B0h suspends again.
- R8: AAh@555h, 55h@2AAh, 20h@555h sets `bypass_on`.
- R9: In bypass mode A0h at any address, then a PA/PD write, starts a program as in R2. `bypass_on` stays 1 after it completes.
- R10: In bypass mode erase sequences start nothing, and the mode is kept.
- R11: In bypass mode 90h followed by 00h clears `bypass_on`, after which a lone A0h no longer arms a program. 90h followed by any other byte keeps bypass mode.
- R12: 98h at any address in read mode sets `rd_sel`=1 (query). Other writes keep it until an F0h write, which returns `rd_sel` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Bus write address |
| bus_wdata | input | 8 | Bus write data byte |
| algo_done | input | 1 | Embedded controller finished the current job |
| op_start | output | 1 | One-cycle job launch pulse |
| op_kind | output | 2 | Job code: 0 none, 1 program, 2 sector erase, 3 chip erase |
| op_addr | output | ADDR_W | Job address |
| op_data | output | 8 | Program data |
| op_busy | output | 1 | A job is in progress (running or held) |
| erase_held | output | 1 | The running erase is suspended |
| bypass_on | output | 1 | Program-bypass mode active |
| rd_sel | output | 2 | Read source: 0 array, 1 query, 2 status |

## Verification
Every result is registered once. `op_start`, `op_busy`, `erase_held`, `bypass_on` and `rd_sel` are therefore due on the cycle right after the clock edge that samples the causing write or `algo_done`. The bench drives each write for one cycle starting at a falling edge and checks at the next falling edge, which is half a cycle after that sampling edge. It checks the one-cycle width of `op_start` one cycle later again. Two sweeps feed all 256 bytes, one as the third command cycle and one as a write during a running erase. The expected outcome of each byte is computed in the bench.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam logic [7:0] K_UNLK_1   = 8'hAA;
    localparam logic [7:0] K_UNLK_2   = 8'h55;
    localparam logic [7:0] K_PROG     = 8'hA0;
    localparam logic [7:0] K_ERASE    = 8'h80;
    localparam logic [7:0] K_CHIP     = 8'h10;
    localparam logic [7:0] K_SECTOR   = 8'h30;
    localparam logic [7:0] K_HOLD     = 8'hB0;
    localparam logic [7:0] K_BYP_IN   = 8'h20;
    localparam logic [7:0] K_BYP_OUT1 = 8'h90;
    localparam logic [7:0] K_BYP_OUT2 = 8'h00;
    localparam logic [7:0] K_QUERY    = 8'h98;
    localparam logic [7:0] K_RESET    = 8'hF0;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_PROG   = 2'd1,
        OP_SECTOR = 2'd2,
        OP_CHIP   = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_QUERY  = 2'd1,
        RD_STATUS = 2'd2
    } rd_sel_e;

    typedef enum logic [3:0] {
        S_READ, S_UNLK1, S_UNLK2, S_PSET,
        S_ERS1, S_ERS2, S_ERS3,
        S_QUERY, S_BYP, S_BYP_PSET, S_BYP_EXIT
    } seq_state_e;

    typedef struct packed {
        logic       valid;
        logic       first;
        logic       second;
        logic       at_base;
        logic [7:0] code;
    } wr_class_t;

    function automatic logic is_erase(op_kind_e k);
        return (k == OP_SECTOR) || (k == OP_CHIP);
    endfunction

endpackage

// File: rtl/flash_wr_decode.sv
module flash_wr_decode
    import flash_seq_pkg::*;
#(
    parameter int          ADDR_W = 12,
    parameter logic [ADDR_W-1:0] BASE_A = 12'h555,
    parameter logic [ADDR_W-1:0] BASE_B = 12'h2AA
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output wr_class_t         cls
);
    always_comb begin
        cls.valid   = we;
        cls.code    = data;
        cls.at_base = (addr == BASE_A);
        cls.first   = we && (addr == BASE_A) && (data == K_UNLK_1);
        cls.second  = we && (addr == BASE_B) && (data == K_UNLK_2);
    end
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wr_class_t cls,
    input  logic      busy,
    output logic      launch,
    output op_kind_e  launch_kind,
    output logic      query_on,
    output logic      bypass_on
);
    seq_state_e st_q, st_d;
    logic       take;

    assign take = cls.valid && !busy;

    always_comb begin
        st_d        = st_q;
        launch      = 1'b0;
        launch_kind = OP_NONE;
        if (take) begin
            case (st_q)
                S_READ: begin
                    if (cls.first)                 st_d = S_UNLK1;
                    else if (cls.code == K_QUERY)  st_d = S_QUERY;
                end
                S_UNLK1: st_d = cls.second ? S_UNLK2 : S_READ;
                S_UNLK2: begin
                    st_d = S_READ;
                    if (cls.at_base) begin
                        if (cls.code == K_PROG)        st_d = S_PSET;
                        else if (cls.code == K_ERASE)  st_d = S_ERS1;
                        else if (cls.code == K_BYP_IN) st_d = S_BYP;
                    end
                end
                S_PSET: begin
                    launch      = 1'b1;
                    launch_kind = OP_PROG;
                    st_d        = S_READ;
                end
                S_ERS1: st_d = cls.first  ? S_ERS2 : S_READ;
                S_ERS2: st_d = cls.second ? S_ERS3 : S_READ;
                S_ERS3: begin
                    st_d = S_READ;
                    if (cls.at_base && cls.code == K_CHIP) begin
                        launch      = 1'b1;
                        launch_kind = OP_CHIP;
                    end else if (cls.code == K_SECTOR) begin
                        launch      = 1'b1;
                        launch_kind = OP_SECTOR;
                    end
                end
                S_QUERY: if (cls.code == K_RESET) st_d = S_READ;
                S_BYP: begin
                    if (cls.code == K_PROG)          st_d = S_BYP_PSET;
                    else if (cls.code == K_BYP_OUT1) st_d = S_BYP_EXIT;
                end
                S_BYP_PSET: begin
                    launch      = 1'b1;
                    launch_kind = OP_PROG;
                    st_d        = S_BYP;
                end
                S_BYP_EXIT: st_d = (cls.code == K_BYP_OUT2) ? S_READ : S_BYP;
                default: st_d = S_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= S_READ;
        else     st_q <= st_d;
    end

    assign query_on  = (st_q == S_QUERY);
    assign bypass_on = (st_q == S_BYP) || (st_q == S_BYP_PSET) || (st_q == S_BYP_EXIT);
endmodule

// File: rtl/flash_op_tracker.sv
module flash_op_tracker
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [7:0]        wr_code,
    input  logic              launch,
    input  op_kind_e          launch_kind,
    input  logic [ADDR_W-1:0] launch_addr,
    input  logic [7:0]        launch_data,
    input  logic              algo_done,
    output logic              start,
    output op_kind_e          kind,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        data,
    output logic              busy,
    output logic              held
);
    logic erasing;
    assign erasing = busy && is_erase(kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            start <= 1'b0;
            kind  <= OP_NONE;
            addr  <= '0;
            data  <= '0;
            busy  <= 1'b0;
            held  <= 1'b0;
        end else begin
            start <= launch;
            if (launch) begin
                busy <= 1'b1;
                kind <= launch_kind;
                addr <= launch_addr;
                data <= launch_data;
            end else if (busy && !held && algo_done) begin
                busy <= 1'b0;
                kind <= OP_NONE;
            end
            if (erasing && wr_valid) begin
                if (!held && !algo_done && wr_code == K_HOLD) held <= 1'b1;
                else if (held && wr_code == K_SECTOR)         held <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int          ADDR_W = 12,
    parameter logic [ADDR_W-1:0] BASE_A = 12'h555,
    parameter logic [ADDR_W-1:0] BASE_B = 12'h2AA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              algo_done,
    output logic              op_start,
    output logic [1:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic              op_busy,
    output logic              erase_held,
    output logic              bypass_on,
    output logic [1:0]        rd_sel
);
    wr_class_t cls;
    logic      launch, query_on;
    op_kind_e  launch_kind, kind_q;
    rd_sel_e   sel;

    flash_wr_decode #(.ADDR_W(ADDR_W), .BASE_A(BASE_A), .BASE_B(BASE_B)) u_dec (
        .we(bus_we), .addr(bus_addr), .data(bus_wdata), .cls(cls)
    );

    flash_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .cls(cls), .busy(op_busy),
        .launch(launch), .launch_kind(launch_kind),
        .query_on(query_on), .bypass_on(bypass_on)
    );

    flash_op_tracker #(.ADDR_W(ADDR_W)) u_trk (
        .clk(clk), .rst(rst),
        .wr_valid(bus_we), .wr_code(bus_wdata),
        .launch(launch), .launch_kind(launch_kind),
        .launch_addr(bus_addr), .launch_data(bus_wdata),
        .algo_done(algo_done),
        .start(op_start), .kind(kind_q), .addr(op_addr), .data(op_data),
        .busy(op_busy), .held(erase_held)
    );

    always_comb begin
        if (op_busy && !erase_held) sel = RD_STATUS;
        else if (query_on)          sel = RD_QUERY;
        else                        sel = RD_ARRAY;
    end

    assign op_kind = kind_q;
    assign rd_sel  = sel;
endmodule

// File: rtl/flash_cmd_seq_checker.sv
module flash_cmd_seq_checker (
    input logic       clk,
    input logic       rst,
    input logic       bus_we,
    input logic [7:0] bus_wdata,
    input logic       algo_done,
    input logic       op_start,
    input logic [1:0] op_kind,
    input logic       op_busy,
    input logic       erase_held,
    input logic       bypass_on,
    input logic [1:0] rd_sel
);
    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        op_start |-> op_busy);

    a_r2_start_single: assert property (@(posedge clk) disable iff (rst)
        op_start |=> !op_start);

    a_r5_status_sel: assert property (@(posedge clk) disable iff (rst)
        (op_busy && !erase_held) |-> rd_sel == 2'd2);

    a_r6_held_is_erase: assert property (@(posedge clk) disable iff (rst)
        erase_held |-> (op_busy && op_kind[1]));

    a_r6_hold_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(erase_held) |-> $past(bus_we && bus_wdata == 8'hB0));

    a_r6_done_ignored: assert property (@(posedge clk) disable iff (rst)
        (erase_held && algo_done && !bus_we) |=> (op_busy && erase_held));

    a_r10_bypass_prog_only: assert property (@(posedge clk) disable iff (rst)
        (bypass_on && op_start) |-> op_kind == 2'd1);
endmodule

bind flash_cmd_seq flash_cmd_seq_checker u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .algo_done(algo_done), .op_start(op_start), .op_kind(op_kind),
    .op_busy(op_busy), .erase_held(erase_held), .bypass_on(bypass_on),
    .rd_sel(rd_sel)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        algo_done = 1'b0;
    logic        op_start, op_busy, erase_held, bypass_on;
    logic [1:0]  op_kind, rd_sel;
    logic [11:0] op_addr;
    logic [7:0]  op_data;
    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    flash_cmd_seq u_flash_cmd_seq (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .algo_done(algo_done), .op_start(op_start),
        .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
        .op_busy(op_busy), .erase_held(erase_held), .bypass_on(bypass_on),
        .rd_sel(rd_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        algo_done = 1'b1;
        @(negedge clk);
        algo_done = 1'b0;
    endtask

    task automatic unlock();
        wr(12'h555, 8'hAA);
        wr(12'h2AA, 8'h55);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 busy", op_busy, 0);
        chk("R1 held", erase_held, 0);
        chk("R1 bypass", bypass_on, 0);
        chk("R1 rd_sel", rd_sel, 0);
        chk("R1 start", op_start, 0);

        // R2 standard program
        unlock(); wr(12'h555, 8'hA0); wr(12'h321, 8'h5C);
        chk("R2 start", op_start, 1);
        chk("R2 kind", op_kind, 1);
        chk("R2 addr", op_addr, 12'h321);
        chk("R2 data", op_data, 8'h5C);
        chk("R2 busy", op_busy, 1);
        chk("R5 status", rd_sel, 2);
        @(negedge clk);
        chk("R2 pulse width", op_start, 0);
        // R5 writes ignored while busy; B0 during program ignored (R6)
        wr(12'h055, 8'h98);
        wr(12'h010, 8'hB0);
        chk("R6 hold on program", erase_held, 0);
        done_pulse();
        chk("R2 busy clear", op_busy, 0);
        chk("R5 query ignored", rd_sel, 0);

        // R3 mismatches
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h54); wr(12'h555, 8'hA0); wr(12'h100, 8'h11);
        chk("R3 bad second byte", op_start, 0);
        wr(12'h556, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(12'h100, 8'h11);
        chk("R3 bad first addr", op_start, 0);
        unlock(); wr(12'h554, 8'hA0); wr(12'h100, 8'h11);
        chk("R3 bad third addr", op_start, 0);
        chk("R3 busy", op_busy, 0);

        // R4 erases
        unlock(); wr(12'h555, 8'h80); unlock(); wr(12'h400, 8'h30);
        chk("R4 sector start", op_start, 1);
        chk("R4 sector kind", op_kind, 2);
        chk("R4 sector addr", op_addr, 12'h400);
        done_pulse();
        unlock(); wr(12'h555, 8'h80); unlock(); wr(12'h555, 8'h10);
        chk("R4 chip start", op_start, 1);
        chk("R4 chip kind", op_kind, 3);
        done_pulse();
        chk("R4 done", op_busy, 0);

        // R6 / R7 suspend and resume
        unlock(); wr(12'h555, 8'h80); unlock(); wr(12'h600, 8'h30);
        wr(12'h007, 8'hB0);
        chk("R6 held", erase_held, 1);
        chk("R6 rd array", rd_sel, 0);
        done_pulse();
        chk("R6 done ignored", op_busy, 1);
        wr(12'h123, 8'h30);
        chk("R7 resumed", erase_held, 0);
        chk("R7 no start", op_start, 0);
        wr(12'h124, 8'h30);
        chk("R7 second resume", erase_held, 0);
        chk("R7 kind kept", op_kind, 2);
        chk("R7 no restart", op_start, 0);
        wr(12'h000, 8'hB0);
        chk("R7 suspend again", erase_held, 1);
        wr(12'h000, 8'h30);
        // R6 sweep: only B0 suspends
        for (int b = 0; b < 256; b++) begin
            wr(12'h0AB, b[7:0]);
            chk("R6 sweep held", erase_held, (b == 8'hB0) ? 1 : 0);
            chk("R5 sweep start", op_start, 0);
            if (erase_held) wr(12'h0AB, 8'h30);
        end
        done_pulse();
        chk("R6 erase finished", op_busy, 0);

        // R8 / R9 / R10 / R11 bypass
        unlock(); wr(12'h555, 8'h20);
        chk("R8 bypass", bypass_on, 1);
        wr(12'h000, 8'hA0); wr(12'h222, 8'h33);
        chk("R9 start", op_start, 1);
        chk("R9 kind", op_kind, 1);
        chk("R9 addr", op_addr, 12'h222);
        done_pulse();
        chk("R9 bypass kept", bypass_on, 1);
        wr(12'h555, 8'h80); unlock(); wr(12'h555, 8'h80); unlock(); wr(12'h555, 8'h10);
        chk("R10 no erase", op_start, 0);
        chk("R10 idle", op_busy, 0);
        chk("R10 bypass kept", bypass_on, 1);
        wr(12'h000, 8'h90); wr(12'h000, 8'h12);
        chk("R11 partial exit", bypass_on, 1);
        wr(12'h000, 8'h90); wr(12'h000, 8'h00);
        chk("R11 exit", bypass_on, 0);
        wr(12'h000, 8'hA0); wr(12'h222, 8'h44);
        chk("R11 lone A0", op_start, 0);

        // R12 query
        wr(12'h055, 8'h98);
        chk("R12 query", rd_sel, 1);
        wr(12'h010, 8'h00);
        chk("R12 query kept", rd_sel, 1);
        wr(12'h010, 8'hF0);
        chk("R12 query exit", rd_sel, 0);

        // third-cycle sweep (R2, R3, R4, R8)
        for (int b = 0; b < 256; b++) begin
            unlock(); wr(12'h555, b[7:0]); wr(12'h123, 8'h5A);
            chk("R2 R3 sweep start", op_start, (b == 8'hA0) ? 1 : 0);
            chk("R8 R3 sweep bypass", bypass_on, (b == 8'h20) ? 1 : 0);
            if (op_busy) done_pulse();
            if (bypass_on) begin wr(12'h0, 8'h90); wr(12'h0, 8'h00); end
            chk("R3 sweep idle", op_busy, 0);
        end
        summary();
    end
endmodule